// File: doc/BRIEF.md
# Cascaded Three-Word Event Interrupt Controller

This block collects single-cycle event strobes from up to 96 sources into three 32-bit pending words and folds them onto three interrupt lines. Each source is identified by a 7-bit event index presented with a valid strobe. Event n lands in bit n mod 32 of pending word n/32. Events that land in the upper two words also raise a cascade summary bit in the lowest word, so software that looks only at word 0 can tell that something higher up is waiting.

Each interrupt line has its own set of three mask words, one per pending word. A line is high whenever any pending bit is also enabled in that line's mask set. Software reaches all twelve words through a simple register port. Writes to the pending words clear the bits written as one, with per-word exceptions. Mask words are plain read/write storage. Reads are combinational from the current register contents.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every pending word and every mask word reads zero and all three interrupt lines are low.
- R2: A strobe with index n below 96 sets bit n mod 32 of pending word n/32 (address n/32), readable the cycle after the strobe.
- R3: An index from 32 to 63 also sets bit 30 of pending word 0. An index from 64 to 95 also sets bit 31 of pending word 0.
- R4: A write to address 0 clears each pending word 0 bit written as one, except bits 31 and 30, which keep their value.
- R5: A write to address 1 leaves pending word 1 unchanged.
- R6: A write to address 2 clears each pending word 2 bit written as one. When word 2 is zero after that, bit 31 of word 0 clears in the same cycle. Otherwise bit 31 stays set.
- R7: Mask word w of set s (s, w in 0..2) lives at address 3 + 3*s + w. It stores the full 32-bit written value and reads it back.
- R8: Interrupt line s (bit s of the output) is high exactly when some pending bit is also set in the matching word of mask set s. The line follows every mask write and every pending clear.
- R9: When a strobe and a clearing write hit the same pending bit in the same cycle, the bit ends up set. Its cascade bit is then also kept.
- R10: Strobes with index 96 to 127 change no register.
- R11: Reads of addresses 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe |
| evt_idx | input | 7 | Event index |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 3 | Interrupt lines, one per mask set |

## Verification
The bench targets the cascade bits, which a careless design would let software clear. It also checks that bit 31 clears when a word-2 clear empties that word and stays set when bits remain; a design that tracked only the write would drop it early or never. A strobe that collides with a clearing write must leave the bit set, so a clear-wins design loses the event. The bench writes to the read-only word and strobes out-of-range indices, and a design that decoded loosely would corrupt stored state in both cases. It also moves the masks across all three sets to catch a line wired to the wrong mask word.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [0:0] {
    CLR_W1C  = 1'b0,
    CLR_NONE = 1'b1
  } clr_policy_e;

  function automatic int unsigned mask_addr(input int unsigned nwords,
                                            input int unsigned set_i,
                                            input int unsigned word_i);
    return nwords + set_i * nwords + word_i;
  endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                                 evt_valid,
  input  logic [IDX_W-1:0]                     evt_idx,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]     set_o
);
  localparam int unsigned TOTAL = WORD_W * NUM_WORDS;

  always_comb begin
    for (int k = 0; k < NUM_WORDS; k++) begin
      set_o[k] = '0;
      if (evt_valid && (int'(evt_idx) < TOTAL) &&
          (int'(evt_idx) / WORD_W == k))
        set_o[k][int'(evt_idx) % WORD_W] = 1'b1;
    end
  end
endmodule

// File: rtl/evt_pend_word.sv
module evt_pend_word
  import evt_irq_pkg::*;
#(
  parameter int unsigned  WORD_W = 32,
  parameter clr_policy_e  POLICY = CLR_W1C,
  parameter logic [31:0]  PROT   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_i,
  input  logic              sw_clr_en,
  input  logic [WORD_W-1:0] sw_clr_i,
  input  logic [WORD_W-1:0] hw_clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              emptied_o
);
  logic [WORD_W-1:0] word_q, word_d, clr_v;
  logic              upd;

  always_comb begin
    clr_v = hw_clr_i;
    if (sw_clr_en && (POLICY == CLR_W1C))
      clr_v = clr_v | (sw_clr_i & ~PROT[WORD_W-1:0]);
    word_d    = (word_q & ~clr_v) | set_i;
    upd       = (|set_i) || (|clr_v);
    emptied_o = (|clr_v) && (word_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (upd) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_SETS  = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              reg_wr,
  input  logic [ADDR_W-1:0]                                 reg_addr,
  input  logic [WORD_W-1:0]                                 reg_wdata,
  output logic [NUM_SETS-1:0][NUM_WORDS-1:0][WORD_W-1:0]    mask_o
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int unsigned MY_ADDR = mask_addr(NUM_WORDS, s, w);
      logic [WORD_W-1:0] m_q;
      logic              m_en;

      always_comb m_en = reg_wr && (int'(reg_addr) == MY_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    m_q <= '0;
        else if (m_en) m_q <= reg_wdata;
      end

      assign mask_o[s][w] = m_q;
    end
  end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_SETS  = 3
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]               pend_i,
  input  logic [NUM_SETS-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask_i,
  output logic [NUM_SETS-1:0]                            irq_o
);
  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      irq_o[s] = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
        irq_o[s] = irq_o[s] | (|(pend_i[w] & mask_i[s][w]));
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_SETS  = 3,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [31:0] RO_WORDS  = 32'h2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [IDX_W-1:0]    evt_idx,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [NUM_SETS-1:0] irq_o
);
  localparam int unsigned CASC_LO = WORD_W - NUM_WORDS + 1;
  localparam int unsigned N_REGS  = NUM_WORDS * (1 + NUM_SETS);

  logic [NUM_WORDS-1:0][WORD_W-1:0]               set_raw, set_w, hw_clr, pend_q;
  logic [NUM_WORDS-1:0]                           emptied, clr_en;
  logic [NUM_SETS-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask_q;

  evt_decode #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .evt_valid (evt_valid),
    .evt_idx   (evt_idx),
    .set_o     (set_raw)
  );

  // Cascade routing: word k (k >= 1) owns bit CASC_LO + k - 1 of word 0.
  always_comb begin
    set_w  = set_raw;
    hw_clr = '0;
    for (int k = 1; k < NUM_WORDS; k++) begin
      set_w[0][CASC_LO + k - 1]  = set_raw[0][CASC_LO + k - 1] | (|set_raw[k]);
      hw_clr[0][CASC_LO + k - 1] = emptied[k];
    end
    for (int k = 0; k < NUM_WORDS; k++)
      clr_en[k] = reg_wr && (int'(reg_addr) == k);
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pend
    localparam clr_policy_e POL  = RO_WORDS[k] ? CLR_NONE : CLR_W1C;
    localparam logic [31:0] PMSK = (k == 0) ?
      (((32'h1 << (NUM_WORDS - 1)) - 32'h1) << CASC_LO) : 32'h0;
    evt_pend_word #(.WORD_W(WORD_W), .POLICY(POL), .PROT(PMSK)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_w[k]),
      .sw_clr_en (clr_en[k]),
      .sw_clr_i  (reg_wdata),
      .hw_clr_i  (hw_clr[k]),
      .word_o    (pend_q[k]),
      .emptied_o (emptied[k])
    );
  end

  evt_mask_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_SETS(NUM_SETS),
                  .ADDR_W(ADDR_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mask_o    (mask_q)
  );

  evt_irq_reduce #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_SETS(NUM_SETS)) u_red (
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) < NUM_WORDS) begin
      reg_rdata = pend_q[int'(reg_addr)];
    end else if (int'(reg_addr) < N_REGS) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WORDS; w++)
          if (int'(reg_addr) == mask_addr(NUM_WORDS, s, w))
            reg_rdata = mask_q[s][w];
    end
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_SETS  = 3,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          evt_valid,
  input logic [IDX_W-1:0]              evt_idx,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [NUM_WORDS*WORD_W-1:0]   pend_flat,
  input logic [NUM_SETS-1:0]           irq
);
  localparam int unsigned TOTAL   = WORD_W * NUM_WORDS;
  localparam int unsigned CASC_LO = WORD_W - NUM_WORDS + 1;

  // R2 and R9: an accepted strobe always leaves its bit set
  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (int'(evt_idx) < TOTAL)) |=> pend_flat[$past(evt_idx)]);

  // R3: upper-word strobes raise their cascade bit in word 0
  p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (int'(evt_idx) >= WORD_W) && (int'(evt_idx) < TOTAL)) |=>
    pend_flat[CASC_LO - 1 + int'($past(evt_idx)) / WORD_W]);

  // R4 and R6: the top cascade bit falls only after a write to the top word
  p_casc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_flat[WORD_W-1]) |-> $past(reg_wr && (int'(reg_addr) == NUM_WORDS - 1)));

  // R5: word 1 is untouched by a write when no strobe arrives
  p_ro_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (int'(reg_addr) == 1) && !evt_valid) |=>
    $stable(pend_flat[2*WORD_W-1:WORD_W]));

  // R8: a line only drops after a register write
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_irq
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[s]) |-> $past(reg_wr));
  end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_SETS(NUM_SETS),
  .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_idx   (evt_idx),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .pend_flat (pend_q),
  .irq       (irq_o)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [6:0]  evt_idx;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, captured at the next rising edge.
  task automatic step(input bit ev, input int idx, input bit wr,
                      input int addr, input logic [31:0] data);
    @(negedge clk);
    evt_valid = ev; evt_idx = 7'(idx);
    reg_wr = wr; reg_addr = 4'(addr); reg_wdata = data;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] v);
    reg_addr = 4'(addr);
    #0.5;
    v = reg_rdata;
  endtask

  task automatic chk_rd(input string req, input int addr, input logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 12; a++) chk_rd("R1 reset word", a, 32'h0);
    chk("R1 reset irq", {29'h0, irq_o}, 32'h0);
  endtask

  task automatic t_events();
    step(1, 5, 0, 0, 0);
    step(1, 40, 0, 0, 0);
    step(1, 70, 0, 0, 0);
    chk_rd("R2/R3 word0", 0, 32'hC000_0020);
    chk_rd("R2 word1", 1, 32'h0000_0100);
    chk_rd("R2 word2", 2, 32'h0000_0040);
  endtask

  task automatic t_oob();
    step(1, 100, 0, 0, 0);
    step(1, 127, 0, 0, 0);
    chk_rd("R10 word0", 0, 32'hC000_0020);
    chk_rd("R10 word1", 1, 32'h0000_0100);
    chk_rd("R10 word2", 2, 32'h0000_0040);
  endtask

  task automatic t_w0_clear();
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    chk_rd("R4 word0 cascade kept", 0, 32'hC000_0000);
  endtask

  task automatic t_w1_ro();
    step(0, 0, 1, 1, 32'hFFFF_FFFF);
    chk_rd("R5 word1 unchanged", 1, 32'h0000_0100);
  endtask

  task automatic t_w2_clear();
    step(1, 65, 0, 0, 0);
    step(0, 0, 1, 2, 32'h0000_0002);
    chk_rd("R6 partial word2", 2, 32'h0000_0040);
    chk_rd("R6 bit31 kept", 0, 32'hC000_0000);
    step(0, 0, 1, 2, 32'h0000_0040);
    chk_rd("R6 word2 empty", 2, 32'h0);
    chk_rd("R6 bit31 dropped", 0, 32'h4000_0000);
  endtask

  task automatic t_masks();
    for (int a = 3; a < 12; a++) step(0, 0, 1, a, 32'h1111_0000 * a + 32'(a));
    for (int a = 3; a < 12; a++) chk_rd("R7 mask readback", a, 32'h1111_0000 * a + 32'(a));
    for (int a = 3; a < 12; a++) step(0, 0, 1, a, 32'h0);
    chk("R8 all masks clear", {29'h0, irq_o}, 32'h0);
  endtask

  task automatic t_irq();
    step(0, 0, 1, 7, 32'h0000_0100);          // set 1, word 1
    chk("R8 line B", {29'h0, irq_o}, 32'h2);
    step(0, 0, 1, 9, 32'h4000_0000);          // set 2, word 0, cascade bit
    chk("R8 lines B,C", {29'h0, irq_o}, 32'h6);
    step(0, 0, 1, 7, 32'h0);
    step(0, 0, 1, 9, 32'h0);
    chk("R8 masks removed", {29'h0, irq_o}, 32'h0);
    step(0, 0, 1, 3, 32'h0000_0008);          // set 0, word 0
    step(1, 3, 0, 0, 0);
    chk("R8 line A on event", {29'h0, irq_o}, 32'h1);
    step(0, 0, 1, 0, 32'h0000_0008);
    chk("R8 line A after clear", {29'h0, irq_o}, 32'h0);
    step(0, 0, 1, 3, 32'h0);
  endtask

  task automatic t_race();
    step(1, 7, 1, 0, 32'h0000_0080);
    chk_rd("R9 raise beats clear w0", 0, 32'h4000_0080);
    step(1, 66, 1, 2, 32'hFFFF_FFFF);
    chk_rd("R9 raise beats clear w2", 2, 32'h0000_0004);
    chk_rd("R9 cascade kept", 0, 32'hC000_0080);
  endtask

  task automatic t_unused();
    for (int a = 12; a < 16; a++) chk_rd("R11 unused address", a, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_idx = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_oob();
    t_w0_clear();
    t_w1_ro();
    t_w2_clear();
    t_masks();
    t_irq();
    t_race();
    t_unused();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..R11 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule